// File: doc/BRIEF.md
# Operand Specifier Address Evaluator

This block takes the bytes of one general operand specifier from an instruction stream and works out where the operand lives. It returns one of three things: a register number, a short constant carried inside the specifier, or a 32-bit effective address. Along the way it carries out any register side effect of the addressing mode, such as a post-increment or pre-decrement. The instruction decoder sets the operand size code and the stream address of the first specifier byte. It then feeds bytes through a valid/ready handshake and waits for a one-cycle completion pulse. On that pulse the block also reports the stream address just past the last byte it consumed.

The specifier byte holds the mode in its upper nibble and the register number in its lower nibble. Some modes need more input. Displacement modes take 1, 2 or 4 extension bytes. The program-counter immediate and absolute forms take their data from the stream. Deferred modes fetch a longword pointer through a memory read port. An index prefix scales a second register by the operand size and adds it to the address of the base specifier that follows.

The register file is outside the block. The block reaches it through one combinational read port and one write port. Register 15 is the program counter. The block never reads or writes it through the file. It substitutes its own count of the stream position instead.

Top module: `opnd_spec_eval`

## Requirements
- R1: Modes 0 to 3 give result kind 1 (constant). The result value is bits 5:0 of the specifier byte, zero-extended. Only that one byte is consumed.
- R2: Mode 5 gives result kind 0 (register), with the register number as the value. No register is written.
- R3: Mode 6 gives result kind 2 (address), with the register contents as the address.
- R4: Mode 8 (register not 15) returns the register contents as the address and then adds the operand size to the register. Mode 7 (register not 15) first subtracts the size from the register and returns the new value as the address. Size codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes.
- R5: Mode 9 (register not 15) reads a longword at the register's address and returns the read data as the address. It also adds 4 to the register.
- R6: Modes A/B, C/D and E/F take a 1-, 2- or 4-byte little-endian displacement. The displacement is sign-extended and added to the register. The odd mode of each pair then reads a longword at that sum, and the read data is the address.
- R7: A read of register 15 yields the stream address just past the bytes consumed so far, where the first specifier byte sits at spec_pc. Register 15 is never written through the write port.
- R8: Mode 8 with register 15 returns, as the address, the stream position just past the specifier byte. It then skips size-many bytes. Mode 9 with register 15 takes the next four bytes, little-endian, as the address.
- R9: A byte with mode 4 is an index prefix. The named register, read when the prefix is consumed, is shifted left by the size code and added to the final address of the next specifier.
- R10: An index prefix followed by a mode 0 to 5 byte gives kind 3 (fault) with value 0. So does mode 7 on register 15.
- R11: done is high for exactly one cycle per operand. next_pc is then the stream address just past the last consumed byte.
- R12: mem_req stays high with a stable mem_addr until mem_ack. No stream byte is accepted while a read is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_valid | input | 1 | Stream byte present |
| byte_data | input | 8 | Stream byte |
| byte_ready | output | 1 | Block accepts a byte this cycle |
| opsize | input | 2 | Operand size code, sampled with the first byte |
| spec_pc | input | AW | Stream address of the first byte of the operand |
| rf_raddr | output | 4 | Register read select |
| rf_rdata | input | AW | Register read data (combinational) |
| rf_we | output | 1 | Register write strobe |
| rf_waddr | output | 4 | Register write select |
| rf_wdata | output | AW | Register write data |
| mem_req | output | 1 | Longword read request |
| mem_addr | output | AW | Read address |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | AW | Read data |
| done | output | 1 | Result valid pulse |
| out_kind | output | 2 | 0 register, 1 constant, 2 address, 3 fault |
| out_val | output | AW | Register number, constant or address |
| next_pc | output | AW | Stream address after the operand |

## Verification
The hardest situation to reach combines an index prefix with a program-counter-based or deferred base specifier. The prefix, any extension bytes and a stalled memory read all shift the stream position, and the value of register 15 depends on that position. The bench builds such sequences directly: index on register 15, indexed immediate, and indexed displacement-deferred. It inserts idle gaps between bytes and holds every memory read for several cycles. A behavioural model parses the same bytes independently and predicts the address, next_pc and register write.

// File: rtl/opnd_spec_eval.sv
module opnd_spec_eval #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_valid,
  input  logic [7:0]    byte_data,
  output logic          byte_ready,
  input  logic [1:0]    opsize,
  input  logic [AW-1:0] spec_pc,
  output logic [3:0]    rf_raddr,
  input  logic [AW-1:0] rf_rdata,
  output logic          rf_we,
  output logic [3:0]    rf_waddr,
  output logic [AW-1:0] rf_wdata,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [AW-1:0] mem_rdata,
  output logic          done,
  output logic [1:0]    out_kind,
  output logic [AW-1:0] out_val,
  output logic [AW-1:0] next_pc
);
  localparam logic [2:0] ST_SPEC = 3'd0, ST_IDX = 3'd1, ST_EXT = 3'd2,
                         ST_EXEC = 3'd3, ST_MEM = 3'd4, ST_DONE = 3'd5;
  localparam logic [1:0] K_REG = 2'd0, K_LIT = 2'd1, K_ADDR = 2'd2, K_FLT = 2'd3;

  logic [2:0]    state;
  logic          first_q, idx_on_q;
  logic [1:0]    size_q, kind_q;
  logic [3:0]    mode_q, reg_q, cnt_q, need_q;
  logic [5:0]    lit_q;
  logic [31:0]   ext_q;
  logic [AW-1:0] pc_q, pc_spec_q, idx_val_q, val_q, maddr_q;

  wire [3:0]    bm = byte_data[7:4];
  wire [3:0]    br = byte_data[3:0];
  wire          idx_eff = !first_q && idx_on_q;
  wire [1:0]    sz_code = first_q ? opsize : size_q;
  wire [AW-1:0] pc_nxt = (first_q ? spec_pc : pc_q) + AW'(1);
  wire          bad = (idx_eff && bm <= 4'd5) || (bm == 4'd7 && br == 4'd15);
  wire          pcreg = reg_q == 4'd15;
  wire [AW-1:0] rv = pcreg ? pc_q : rf_rdata;
  wire [AW-1:0] sz = AW'(1) << size_q;

  logic [3:0]    need;
  logic [AW-1:0] disp, ea, wv;
  logic          defer, wr;

  always_comb begin
    need = 4'd0;
    case (bm)
      4'h8:        if (br == 4'd15) need = 4'd1 << sz_code;
      4'h9:        if (br == 4'd15) need = 4'd4;
      4'hA, 4'hB:  need = 4'd1;
      4'hC, 4'hD:  need = 4'd2;
      4'hE, 4'hF:  need = 4'd4;
      default:     need = 4'd0;
    endcase
  end

  always_comb begin
    case (mode_q[2:1])
      2'b01:   disp = AW'($signed(ext_q[7:0]));
      2'b10:   disp = AW'($signed(ext_q[15:0]));
      default: disp = AW'($signed(ext_q));
    endcase
  end

  always_comb begin
    ea = rv; defer = 1'b0; wr = 1'b0; wv = rv + sz;
    case (mode_q)
      4'h7: begin ea = rv - sz; wv = rv - sz; wr = 1'b1; end
      4'h8: if (pcreg) ea = pc_spec_q; else wr = 1'b1;
      4'h9: if (pcreg) ea = AW'(ext_q);
            else begin defer = 1'b1; wr = 1'b1; wv = rv + AW'(4); end
      4'hA, 4'hB, 4'hC, 4'hD, 4'hE, 4'hF: begin ea = rv + disp; defer = mode_q[0]; end
      default: ;
    endcase
  end

  assign byte_ready = (state == ST_SPEC) || (state == ST_EXT);
  assign rf_raddr   = reg_q;
  assign rf_we      = (state == ST_EXEC) && wr && !pcreg;
  assign rf_waddr   = reg_q;
  assign rf_wdata   = wv;
  assign mem_req    = state == ST_MEM;
  assign mem_addr   = maddr_q;
  assign done       = state == ST_DONE;
  assign out_kind   = kind_q;
  assign out_val    = val_q;
  assign next_pc    = pc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_SPEC; first_q <= 1'b1; idx_on_q <= 1'b0; size_q <= 2'd0;
      kind_q <= K_REG; mode_q <= 4'd0; reg_q <= 4'd0; cnt_q <= 4'd0; need_q <= 4'd0;
      lit_q <= 6'd0; ext_q <= 32'd0; pc_q <= '0; pc_spec_q <= '0;
      idx_val_q <= '0; val_q <= '0; maddr_q <= '0;
    end else begin
      case (state)
        ST_SPEC: if (byte_valid) begin
          pc_q <= pc_nxt; pc_spec_q <= pc_nxt;
          mode_q <= bm; reg_q <= br; lit_q <= byte_data[5:0];
          ext_q <= 32'd0; cnt_q <= 4'd0; need_q <= need; first_q <= 1'b0;
          if (first_q) begin size_q <= opsize; idx_on_q <= 1'b0; idx_val_q <= '0; end
          if (bad) begin kind_q <= K_FLT; val_q <= '0; state <= ST_DONE; end
          else if (bm == 4'd4) begin idx_on_q <= 1'b1; state <= ST_IDX; end
          else if (need != 4'd0) state <= ST_EXT;
          else state <= ST_EXEC;
        end
        ST_IDX: begin
          idx_val_q <= rv << size_q;
          state <= ST_SPEC;
        end
        ST_EXT: if (byte_valid) begin
          if (cnt_q < 4'd4) ext_q[{cnt_q[1:0], 3'b000} +: 8] <= byte_data;
          cnt_q <= cnt_q + 4'd1;
          pc_q <= pc_q + AW'(1);
          if (cnt_q + 4'd1 == need_q) state <= ST_EXEC;
        end
        ST_EXEC: begin
          if (mode_q < 4'd4) begin kind_q <= K_LIT; val_q <= AW'(lit_q); state <= ST_DONE; end
          else if (mode_q == 4'd5) begin kind_q <= K_REG; val_q <= AW'(reg_q); state <= ST_DONE; end
          else if (defer) begin maddr_q <= ea; state <= ST_MEM; end
          else begin kind_q <= K_ADDR; val_q <= ea + idx_val_q; state <= ST_DONE; end
        end
        ST_MEM: if (mem_ack) begin
          kind_q <= K_ADDR; val_q <= mem_rdata + idx_val_q; state <= ST_DONE;
        end
        ST_DONE: begin state <= ST_SPEC; first_q <= 1'b1; end
        default: state <= ST_SPEC;
      endcase
    end
  end

  AST_LIT_SIX_BITS: assert property (@(posedge clk) disable iff (!rst_n) done && out_kind == K_LIT |-> out_val < AW'(64)); // R1
  AST_PC_NEVER_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n) rf_we |-> rf_waddr != 4'd15); // R7
  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n) done && out_kind == K_FLT |-> out_val == '0); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R11
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n) mem_req && !mem_ack |=> mem_req && $stable(mem_addr)); // R12
  AST_NO_BYTE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> !byte_ready); // R12
endmodule

// File: tb/tb_opnd_spec_eval.sv
`timescale 1ns/1ps
module tb_opnd_spec_eval;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        byte_valid, byte_ready, rf_we, mem_req, mem_ack, done;
  logic [7:0]  byte_data;
  logic [1:0]  opsize, out_kind;
  logic [3:0]  rf_raddr, rf_waddr;
  logic [31:0] spec_pc, rf_rdata, rf_wdata, mem_addr, mem_rdata, out_val, next_pc;
  logic [31:0] rf_m [16];
  int errors = 0, checks = 0, wr_count = 0, gap = 0, mem_wait = 0;

  assign rf_rdata = rf_m[rf_raddr];

  opnd_spec_eval #(.AW(32)) dut (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
    .byte_ready(byte_ready), .opsize(opsize), .spec_pc(spec_pc),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr),
    .rf_wdata(rf_wdata), .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .done(done), .out_kind(out_kind), .out_val(out_val),
    .next_pc(next_pc));

  always #2.5 clk = ~clk;

  function automatic logic [31:0] memf(input logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h1357_9bdf;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  initial begin : rf_writer
    forever begin
      @(posedge clk);
      if (rf_we) begin
        rf_m[rf_waddr] <= rf_wdata;
        wr_count++;
        chk("R7", "write to pc", {28'd0, rf_waddr} == 32'd15, 32'd0);
      end
    end
  end

  initial begin : mem_model
    mem_ack = 1'b0; mem_rdata = 32'd0;
    forever begin
      @(negedge clk);
      if (mem_req && !mem_ack) begin
        mem_wait++;
        if (mem_wait == 3) begin mem_ack = 1'b1; mem_rdata = memf(mem_addr); mem_wait = 0; end
      end else mem_ack = 1'b0;
    end
  end

  // behavioural reference: parse the byte list and predict the result
  task automatic model(input logic [7:0] q[$], input logic [1:0] szc, input logic [31:0] pc0,
                       output int kind, output logic [31:0] val, output logic [31:0] npc,
                       output int wreg, output logic [31:0] wval);
    int pos = 0, sz = 1 << szc, n;
    logic [31:0] pc = pc0, idx = 0, rv, d, a;
    bit has_idx = 0;
    logic [3:0] m, r;
    kind = 3; val = 0; wreg = -1; wval = 0;
    forever begin
      m = q[pos][7:4]; r = q[pos][3:0]; pos++; pc++;
      rv = (r == 15) ? pc : rf_m[r];
      if (m == 4 && !has_idx) begin idx = rv * sz; has_idx = 1; continue; end
      break;
    end
    if (m <= 5 && has_idx) kind = 3;
    else if (m < 4) begin kind = 1; val = {26'd0, q[pos-1][5:0]}; end
    else if (m == 5) begin kind = 0; val = {28'd0, r}; end
    else if (m == 7 && r == 15) kind = 3;
    else begin
      kind = 2;
      case (m)
        6: a = rv;
        7: begin a = rv - sz; wreg = r; wval = a; end
        8: if (r == 15) begin a = pc; pc += sz; end else begin a = rv; wreg = r; wval = rv + sz; end
        9: if (r == 15) begin a = {q[pos+3], q[pos+2], q[pos+1], q[pos]}; pc += 4; end
           else begin a = memf(rv); wreg = r; wval = rv + 4; end
        default: begin
          n = (m < 12) ? 1 : (m < 14) ? 2 : 4;
          d = 0;
          for (int k = 0; k < n; k++) d[8*k +: 8] = q[pos+k];
          if (n == 1) d = {{24{d[7]}}, d[7:0]};
          if (n == 2) d = {{16{d[15]}}, d[15:0]};
          pc += n;
          rv = (r == 15) ? pc : rf_m[r];
          a = rv + d;
          if (m[0]) a = memf(a);
        end
      endcase
      val = a + idx;
    end
    npc = pc;
  endtask

  task automatic run(input string req, input logic [1:0] szc, input logic [31:0] pc0, input logic [7:0] q[$]);
    int ek, ewr, w0, t;
    logic [31:0] ev, enp, ewv;
    model(q, szc, pc0, ek, ev, enp, ewr, ewv);
    w0 = wr_count;
    opsize = szc; spec_pc = pc0;
    foreach (q[i]) begin
      repeat (gap) @(negedge clk);
      byte_valid = 1'b1; byte_data = q[i];
      while (!byte_ready) @(negedge clk);
      @(negedge clk);
      byte_valid = 1'b0;
    end
    t = 0;
    while (!done && t < 50) begin @(negedge clk); t++; end
    chk(req, "done", {31'd0, done}, 32'd1);
    chk(req, "kind", {30'd0, out_kind}, ek);
    chk(req, "value", out_val, ev);
    chk("R11", "next_pc", next_pc, enp);
    @(negedge clk);
    chk("R11", "done pulse", {31'd0, done}, 32'd0);
    chk(req, "write count", wr_count - w0, (ewr >= 0) ? 1 : 0);
    if (ewr >= 0) chk(req, "register update", rf_m[ewr], ewv);
    gap = (gap + 1) % 3;
  endtask

  initial begin : watchdog
    #1000000;
    errors++; checks++;
    $display("FAIL R11 watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    byte_valid = 1'b0; byte_data = 8'd0; opsize = 2'd0; spec_pc = 32'd0;
    for (int i = 0; i < 16; i++) rf_m[i] <= 32'h0001_0000 * (i + 1) + 32'h40 * i;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", "reset ready", {31'd0, byte_ready}, 32'd1);
    chk("R11", "reset done", {31'd0, done}, 32'd0);
    chk("R12", "reset mem_req", {31'd0, mem_req}, 32'd0);
    chk("R4", "reset rf_we", {31'd0, rf_we}, 32'd0);

    run("R1", 2'd2, 32'h0000_1000, '{8'h2A});
    run("R1", 2'd0, 32'h0000_1010, '{8'h3F});
    run("R2", 2'd2, 32'h0000_1020, '{8'h53});
    run("R3", 2'd2, 32'h0000_1030, '{8'h64});
    run("R4", 2'd1, 32'h0000_1040, '{8'h85});
    run("R4", 2'd3, 32'h0000_1050, '{8'h85});
    run("R4", 2'd1, 32'h0000_1060, '{8'h76});
    run("R5", 2'd2, 32'h0000_1070, '{8'h97});
    run("R6", 2'd2, 32'h0000_1080, '{8'hA2, 8'hF0});
    run("R6", 2'd2, 32'h0000_1090, '{8'hC3, 8'h34, 8'h12});
    run("R6", 2'd2, 32'h0000_10A0, '{8'hC3, 8'h00, 8'h80});
    run("R6", 2'd2, 32'h0000_10B0, '{8'hE4, 8'h78, 8'h56, 8'h34, 8'h92});
    run("R6", 2'd2, 32'h0000_10C0, '{8'hB1, 8'h10});
    run("R7", 2'd2, 32'h0000_10D0, '{8'hAF, 8'hFC});
    run("R7", 2'd2, 32'h0000_10E0, '{8'hDF, 8'h20, 8'h00});
    run("R7", 2'd2, 32'h0000_10F0, '{8'h6F});
    run("R8", 2'd0, 32'h0000_1100, '{8'h8F, 8'h55});
    run("R8", 2'd3, 32'h0000_1110, '{8'h8F, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08});
    run("R8", 2'd2, 32'h0000_1120, '{8'h9F, 8'hEF, 8'hBE, 8'hAD, 8'hDE});
    run("R9", 2'd2, 32'h0000_1130, '{8'h42, 8'h64});
    run("R9", 2'd3, 32'h0000_1140, '{8'h43, 8'hA5, 8'h08});
    run("R9", 2'd1, 32'h0000_1150, '{8'h41, 8'h8F, 8'hAA, 8'hBB});
    run("R9", 2'd2, 32'h0000_1160, '{8'h4F, 8'h66});
    run("R9", 2'd2, 32'h0000_1170, '{8'h46, 8'hDE, 8'h04, 8'h01});
    run("R9", 2'd0, 32'h0000_1180, '{8'h47, 8'h87});
    run("R10", 2'd2, 32'h0000_1190, '{8'h41, 8'h05});
    run("R10", 2'd2, 32'h0000_11A0, '{8'h41, 8'h53});
    run("R10", 2'd2, 32'h0000_11B0, '{8'h41, 8'h42});
    run("R10", 2'd2, 32'h0000_11C0, '{8'h7F});
    run("R3", 2'd2, 32'h0000_11D0, '{8'h65});
    run("R12", 2'd2, 32'h0000_11E0, '{8'hFA, 8'h00, 8'h01, 8'h00, 8'h00});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule